// File: doc/BRIEF.md
# Synchronized Programmable PLL Divider Pair

This block holds the two counters that feed a phase comparator. A main divider runs on the oscillator-side clock and a reference divider runs on the crystal-side clock. Each one emits a single-cycle pulse once per programmed number of its own clock cycles. Division ratios are written through a load strobe in each divider's own clock domain. A written ratio is held as pending and is adopted only when the counter wraps.

A combined enable gates both counters. It is true only when the hardware power-on pin and the software power-on bit both sit at the active level, and a polarity input sets that level. The enable is synchronized separately into each clock domain. While it is low, both counters are held preloaded. When it rises, both start counting from a full interval, so the first compare edges line up with each other and carry no leftover phase.

Top module: `pll_div_pair`

## Requirements
- R1: With main ratio N (17-bit, legal range 512 to 131071), `main_pulse_o` pulses once every N cycles of `clk_vco_i`.
- R2: With reference ratio M (11-bit, legal range 8 to 2047), `ref_pulse_o` pulses once every M cycles of `clk_ref_i`.
- R3: A ratio written below the legal minimum is replaced by that minimum: 512 for main, 8 for reference.
- R4: Each output pulse is high for exactly one cycle of its own clock.
- R5: The block runs only when both `hw_on_i` and `soft_on_i` are at the active level. Otherwise both pulse outputs stay low.
- R6: `pol_i`=1 makes the active level high, and `pol_i`=0 makes it low. The setting applies to both power-on signals.
- R7: When the enable rises, each divider emits its first pulse exactly N+2 of its own clock cycles later: two synchronizer stages plus one full interval.
- R8: A ratio written while a divider runs does not change the interval in progress. It takes effect from the next reload.
- R9: A ratio written while the block is off sets the length of the first interval after power-on.
- R10: After reset both pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco_i | input | 1 | Oscillator-side clock for the main divider |
| clk_ref_i | input | 1 | Crystal-side clock for the reference divider |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pol_i | input | 1 | Active level of the power-on signals (1 = high) |
| hw_on_i | input | 1 | Hardware power-on request |
| soft_on_i | input | 1 | Software power-on bit |
| main_load_i | input | 1 | Main ratio write strobe, clk_vco_i domain |
| main_ratio_i | input | 17 | Main division ratio |
| ref_load_i | input | 1 | Reference ratio write strobe, clk_ref_i domain |
| ref_ratio_i | input | 11 | Reference division ratio |
| main_pulse_o | output | 1 | Main divider terminal-count pulse |
| ref_pulse_o | output | 1 | Reference divider terminal-count pulse |

## Verification
The bench builds the block with its default parameters: 17-bit and 11-bit ratios, minimums of 512 and 8, and two synchronizer stages. With these values the reference maximum of 2047 and both clamp floors can be checked at their true limits. The oscillator clock runs at twice the reference rate. The power-on change is made while both clocks are low, which keeps the N+2 first-pulse latency exact in both domains. Main ratios stay near the low end of the range so that several reload boundaries, including one where the ratio changes mid-interval, fit in a short run.

// File: rtl/pll_pkg.sv
`timescale 1ns/1ps
package pll_pkg;
  typedef enum logic {POL_LOW = 1'b0, POL_HIGH = 1'b1} pol_e;

  function automatic logic is_active(input logic sig, input pol_e pol);
    return sig == logic'(pol);
  endfunction
endpackage

// File: rtl/pll_sync.sv
`timescale 1ns/1ps
module pll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[0] <= 1'b0;
          else         sr_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[i] <= 1'b0;
          else         sr_q[i] <= sr_q[i-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pll_div.sv
`timescale 1ns/1ps
module pll_div #(
  parameter int W   = 17,
  parameter int MIN = 512
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o
);
  localparam logic [W-1:0] MIN_V = W'(MIN);
  localparam logic [W-1:0] ONE   = W'(1);

  logic [W-1:0] pend_q, cnt_q;

  // pending ratio; only read at a reload boundary
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     pend_q <= MIN_V;
    else if (load_i) pend_q <= (ratio_i < MIN_V) ? MIN_V : ratio_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q   <= MIN_V - ONE;
      pulse_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= pend_q - ONE;   // held preloaded while off
      pulse_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q   <= pend_q - ONE;
      pulse_o <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - ONE;
      pulse_o <= 1'b0;
    end

  p_one_wide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  p_quiet_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !pulse_o);
  p_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q >= MIN_V);
  p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q == '0) |=> (cnt_q == $past(pend_q) - ONE));
endmodule

// File: rtl/pll_div_pair.sv
`timescale 1ns/1ps
module pll_div_pair #(
  parameter int MAIN_W      = 17,
  parameter int MAIN_MIN    = 512,
  parameter int REF_W       = 11,
  parameter int REF_MIN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_vco_i,
  input  logic              clk_ref_i,
  input  logic              rst_ni,
  input  logic              pol_i,
  input  logic              hw_on_i,
  input  logic              soft_on_i,
  input  logic              main_load_i,
  input  logic [MAIN_W-1:0] main_ratio_i,
  input  logic              ref_load_i,
  input  logic [REF_W-1:0]  ref_ratio_i,
  output logic              main_pulse_o,
  output logic              ref_pulse_o
);
  import pll_pkg::*;

  logic on_raw, run_main, run_ref;

  assign on_raw = is_active(hw_on_i, pol_e'(pol_i)) &&
                  is_active(soft_on_i, pol_e'(pol_i));

  pll_sync #(.STAGES(SYNC_STAGES)) u_sync_main (
    .clk_i(clk_vco_i), .rst_ni(rst_ni), .d_i(on_raw), .q_o(run_main));

  pll_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
    .clk_i(clk_ref_i), .rst_ni(rst_ni), .d_i(on_raw), .q_o(run_ref));

  pll_div #(.W(MAIN_W), .MIN(MAIN_MIN)) u_div_main (
    .clk_i(clk_vco_i), .rst_ni(rst_ni), .run_i(run_main),
    .load_i(main_load_i), .ratio_i(main_ratio_i), .pulse_o(main_pulse_o));

  pll_div #(.W(REF_W), .MIN(REF_MIN)) u_div_ref (
    .clk_i(clk_ref_i), .rst_ni(rst_ni), .run_i(run_ref),
    .load_i(ref_load_i), .ratio_i(ref_ratio_i), .pulse_o(ref_pulse_o));
endmodule

// File: tb/tb_pll_div_pair.sv
`timescale 1ns/1ps
module tb_pll_div_pair;
  logic clk_vco = 1'b0, clk_ref = 1'b0, rst_n = 1'b0;
  logic pol = 1'b1, hw_on = 1'b0, soft_on = 1'b0;
  logic main_load = 1'b0, ref_load = 1'b0;
  logic [16:0] main_ratio = '0;
  logic [10:0] ref_ratio = '0;
  logic main_pulse, ref_pulse;

  always #4 clk_vco = ~clk_vco;   // 125 MHz
  always #8 clk_ref = ~clk_ref;

  pll_div_pair dut (
    .clk_vco_i(clk_vco), .clk_ref_i(clk_ref), .rst_ni(rst_n),
    .pol_i(pol), .hw_on_i(hw_on), .soft_on_i(soft_on),
    .main_load_i(main_load), .main_ratio_i(main_ratio),
    .ref_load_i(ref_load), .ref_ratio_i(ref_ratio),
    .main_pulse_o(main_pulse), .ref_pulse_o(ref_pulse));

  int checks = 0, failures = 0;
  int q_main[$], q_ref[$];
  string t_main[$], t_ref[$];
  int cnt_m = 0, cnt_r = 0, unexp_m = 0, unexp_r = 0;
  bit arm_m = 0, arm_r = 0, nxt_m = 0, nxt_r = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitors: count own-clock cycles between pulses, compare against queue
  always @(negedge clk_vco) begin
    cnt_m++;
    if (arm_m && nxt_m) chk(!main_pulse, "R4 main width", main_pulse, 0);
    nxt_m = 0;
    if (main_pulse) begin
      if (arm_m) begin
        if (q_main.size() == 0) begin
          unexp_m++;
          chk(0, "R5 unexpected main pulse", cnt_m, 0);
        end else begin
          automatic int e = q_main.pop_front();
          automatic string t = t_main.pop_front();
          chk(cnt_m == e, t, cnt_m, e);
          nxt_m = 1;
        end
      end
      cnt_m = 0;
    end
  end

  always @(negedge clk_ref) begin
    cnt_r++;
    if (arm_r && nxt_r) chk(!ref_pulse, "R4 ref width", ref_pulse, 0);
    nxt_r = 0;
    if (ref_pulse) begin
      if (arm_r) begin
        if (q_ref.size() == 0) begin
          unexp_r++;
          chk(0, "R5 unexpected ref pulse", cnt_r, 0);
        end else begin
          automatic int e = q_ref.pop_front();
          automatic string t = t_ref.pop_front();
          chk(cnt_r == e, t, cnt_r, e);
          nxt_r = 1;
        end
      end
      cnt_r = 0;
    end
  end

  task automatic push_m(input int n, input string t);
    q_main.push_back(n); t_main.push_back(t);
  endtask
  task automatic push_r(input int n, input string t);
    q_ref.push_back(n); t_ref.push_back(t);
  endtask

  task automatic load_m(input int r);
    @(negedge clk_vco); main_ratio = 17'(r); main_load = 1;
    @(negedge clk_vco); main_load = 0;
  endtask
  task automatic load_r(input int r);
    @(negedge clk_ref); ref_ratio = 11'(r); ref_load = 1;
    @(negedge clk_ref); ref_load = 0;
  endtask

  task automatic wait_m(input int n);
    int t = 0;
    while (q_main.size() > n && t < 150000) begin @(negedge clk_vco); t++; end
    if (q_main.size() > n) chk(0, "R1 main timeout", q_main.size(), n);
  endtask
  task automatic wait_r(input int n);
    int t = 0;
    while (q_ref.size() > n && t < 80000) begin @(negedge clk_ref); t++; end
    if (q_ref.size() > n) chk(0, "R2 ref timeout", q_ref.size(), n);
  endtask

  // apply an off combination and confirm both outputs stay silent
  task automatic power_quiet(input logic p, input logic h, input logic s, input string req);
    arm_m = 0; arm_r = 0;
    @(negedge clk_ref); #1;
    pol = p; hw_on = h; soft_on = s;
    repeat (4) @(negedge clk_ref);
    q_main.delete(); t_main.delete(); q_ref.delete(); t_ref.delete();
    unexp_m = 0; unexp_r = 0; arm_m = 1; arm_r = 1;
    repeat (600) @(negedge clk_ref);
    chk(unexp_m == 0, req, unexp_m, 0);
    chk(unexp_r == 0, req, unexp_r, 0);
    arm_m = 0; arm_r = 0;
  endtask

  // turn on while both clocks are low; first pulse at N+2 own cycles
  task automatic power_on(input logic p, input logic h, input logic s,
                          input int nm, input int nr, input string req);
    @(negedge clk_ref); #1;
    pol = p; hw_on = h; soft_on = s;
    cnt_m = 0; cnt_r = 0;
    push_m(nm + 2, {req, " R7 main first"});
    push_r(nr + 2, {req, " R7 ref first"});
    arm_m = 1; arm_r = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk_vco);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_vco);
    chk(main_pulse == 0, "R10 main in reset", main_pulse, 0);
    chk(ref_pulse == 0, "R10 ref in reset", ref_pulse, 0);
    rst_n = 1;
    repeat (3) @(negedge clk_ref);
    chk(main_pulse == 0, "R10 main after reset", main_pulse, 0);
    chk(ref_pulse == 0, "R10 ref after reset", ref_pulse, 0);

    load_m(600);   // written while off
    load_r(10);
    power_quiet(1, 1, 0, "R5 soft bit inactive");
    power_quiet(1, 0, 1, "R5 hw pin inactive");

    power_on(1, 1, 1, 600, 10, "R6 high");
    push_m(600, "R9 main first ratio"); push_m(600, "R1 main period");
    push_r(10, "R9 ref first ratio");   push_r(10, "R2 ref period");
    fork
      begin
        wait_m(1);
        load_m(1000);
        push_m(1000, "R8 main new ratio"); push_m(1000, "R1 main 1000");
        wait_m(1);
        load_m(100);
        push_m(512, "R3 main clamp"); push_m(512, "R3 main clamp again");
        wait_m(0);
        arm_m = 0;
      end
      begin
        wait_r(1);
        load_r(2047);
        push_r(2047, "R2 ref max ratio");
        wait_r(1);
        load_r(3);
        push_r(8, "R3 ref clamp"); push_r(8, "R8 ref after max");
        wait_r(0);
        arm_r = 0;
      end
    join

    power_quiet(0, 1, 1, "R6 low polarity, both high");
    power_quiet(0, 0, 1, "R5 low polarity, soft inactive");
    power_on(0, 0, 0, 512, 8, "R6 low");
    push_m(512, "R1 main after restart");
    push_r(8, "R2 ref after restart");
    fork
      begin wait_m(0); arm_m = 0; end
      begin wait_r(0); arm_r = 0; end
    join

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule